// File: doc/BRIEF.md
# Pipelined Burst SRAM Front End

This block is the clocked front end of a small pipelined burst static memory. On every rising edge it samples address, strobes, chip selects and write enables. It then either starts a four-beat burst, continues or suspends the burst already open, or deselects. Each beat reads or writes one word of an internal register array. A word is made of byte lanes, and each lane carries its own parity bit.

A burst is opened by one of two strobes. The host strobe always opens a read at the external address and ignores the write enables on that edge. The cache-controller strobe opens a cycle only when the host strobe is high, and it decodes the write enables on the same edge. Later beats step through a four-address wrap sequence, either linear or interleaved. Read data leaves through a two-stage pipeline, and an output-drive flag is gated by an asynchronous output enable.

A sleep input parks the block. A two-edge wake-up lockout follows sleep, and any strobe offered during the lockout raises an error pulse.

Top module: `sbram_burst_ctrl`

## Requirements
- R1: While reset is held, rdata is all zeros and dq_oe and strobe_err are low.
- R2: A strobe edge opens a cycle only when sel_a_n=0, sel_b=1 and sel_c_n=0 all hold. Any other combination deselects: no array access is made, and dq_oe is low after that edge even if a read was in flight.
- R3: With sel_a_n high, cpu_stb_n is ignored, so an open burst keeps advancing or suspending under adv_n.
- R4: A cpu_stb_n start reads the word at addr, whatever all_wr_n, byte_wr_n, lane_wr_n and ctl_stb_n are on that edge.
- R5: A ctl_stb_n start happens only when the host strobe is not taking effect. The write enables are decoded on that same edge.
- R6: The write decode works as follows. all_wr_n=0 writes every lane. Otherwise byte_wr_n=0 writes each lane l whose lane_wr_n[l] is 0, and lane l is bits [l*LW +: LW], parity included. Any other case is a read.
- R7: Beat i of a burst from address a keeps the upper bits and replaces the two low bits. The new low bits are (a[1:0]+i) mod 4 when lin_mode=1, and a[1:0] XOR i when lin_mode=0.
- R8: While a burst is open and no strobe takes effect, adv_n=0 moves to the next beat and accesses it. adv_n=1 accesses the current beat again.
- R9: Data read on edge k is on rdata, with dq_oe high, after edge k+1.
- R10: After any edge that performs a write, dq_oe is low whatever oe_n is. dq_oe is also low at any time that oe_n or sleep is high.
- R11: While sleep is high, and for the first two edges after it falls, the block makes no access and leaves the array unchanged.
- R12: A low strobe on either strobe pin during one of those two lockout edges sets strobe_err high for the following cycle. Otherwise strobe_err stays low.
- R13: A read of the word written on the edge just before returns the new lanes merged with the old contents of the unwritten lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | Power-down request, active high |
| lin_mode | input | 1 | 1 selects a linear beat order, 0 selects interleaved |
| oe_n | input | 1 | Output enable, active low, combinational |
| sel_a_n | input | 1 | Chip select, active low; also gates the host strobe |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| cpu_stb_n | input | 1 | Host address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write, active low |
| byte_wr_n | input | 1 | Lane-write qualifier, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| addr | input | AW | Word address |
| wdata | input | LANES*LW | Write data |
| rdata | output | LANES*LW | Registered read data |
| dq_oe | output | 1 | High when the data bus is driven |
| strobe_err | output | 1 | Strobe seen during wake-up lockout |

## Verification
A wrong burst counter or a wrong start address shows up on rdata one edge after the beat concerned, as the data of a different word. The exhaustive sweep over every start address in both beat orders catches it on the first wrong beat. A lost or misrouted pending write shows up two edges after the write, when a read-back returns stale lanes. A wrong pipeline-valid state shows up after the next edge, as dq_oe high after a write, after a deselect or during sleep, or as dq_oe low during a valid read. A wake counter that is off by one shows up at once as an extra or missing strobe_err pulse.

// File: rtl/sbram_burst_ctrl.sv
`timescale 1ns/1ps
module sbram_burst_ctrl #(
  parameter int AW       = 6,
  parameter int LANES    = 2,
  parameter int LW       = 9,
  parameter int WAKE_CYC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep,
  input  logic                lin_mode,
  input  logic                oe_n,
  input  logic                sel_a_n,
  input  logic                sel_b,
  input  logic                sel_c_n,
  input  logic                cpu_stb_n,
  input  logic                ctl_stb_n,
  input  logic                adv_n,
  input  logic                all_wr_n,
  input  logic                byte_wr_n,
  input  logic [LANES-1:0]    lane_wr_n,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] wdata,
  output logic [LANES*LW-1:0] rdata,
  output logic                dq_oe,
  output logic                strobe_err
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;
  localparam int WW    = $clog2(WAKE_CYC + 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    base_q;
  logic [1:0]       cnt_q;
  logic             active_q;
  logic [WW-1:0]    wake_q;
  logic [AW-1:0]    pw_addr_q;
  logic [DW-1:0]    pw_data_q;
  logic [LANES-1:0] pw_mask_q;
  logic [DW-1:0]    st1_q, rdata_q;
  logic             rd1_q, outv_q, err_q;

  logic             awake, all_sel, cpu_go, strobe, start, desel, cont, access;
  logic             do_wr, do_rd;
  logic [LANES-1:0] wr_mask, eff_mask;
  logic [1:0]       cnt_nx, low;
  logic [AW-1:0]    base_nx, acc_addr;
  logic [DW-1:0]    rword;

  assign awake   = !sleep && (wake_q == '0);
  assign all_sel = !sel_a_n && sel_b && !sel_c_n;
  assign cpu_go  = !cpu_stb_n && !sel_a_n;
  assign strobe  = cpu_go || !ctl_stb_n;
  assign start   = awake && strobe && all_sel;
  assign desel   = awake && strobe && !all_sel;
  assign cont    = awake && !strobe && active_q;
  assign access  = start || cont;

  assign wr_mask  = !all_wr_n ? '1 : (!byte_wr_n ? ~lane_wr_n : '0);
  assign eff_mask = (start && cpu_go) ? '0 : wr_mask;
  assign do_wr    = access && (eff_mask != '0);
  assign do_rd    = access && (eff_mask == '0);

  assign base_nx  = start ? addr : base_q;
  assign cnt_nx   = start ? 2'd0 : ((cont && !adv_n) ? cnt_q + 2'd1 : cnt_q);
  assign low      = lin_mode ? (base_nx[1:0] + cnt_nx) : (base_nx[1:0] ^ cnt_nx);
  assign acc_addr = {base_nx[AW-1:2], low};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rword[l*LW +: LW] = (pw_mask_q[l] && pw_addr_q == acc_addr)
                             ? pw_data_q[l*LW +: LW] : mem[acc_addr][l*LW +: LW];
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++)
      if (pw_mask_q[l]) mem[pw_addr_q][l*LW +: LW] <= pw_data_q[l*LW +: LW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      cnt_q     <= '0;
      active_q  <= 1'b0;
      wake_q    <= '0;
      pw_addr_q <= '0;
      pw_data_q <= '0;
      pw_mask_q <= '0;
      st1_q     <= '0;
      rdata_q   <= '0;
      rd1_q     <= 1'b0;
      outv_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (sleep)               wake_q <= WW'(WAKE_CYC);
      else if (wake_q != '0)   wake_q <= wake_q - WW'(1);
      err_q <= !sleep && (wake_q != '0) && (!cpu_stb_n || !ctl_stb_n);

      if (start)      active_q <= 1'b1;
      else if (desel) active_q <= 1'b0;
      if (access) begin
        base_q <= base_nx;
        cnt_q  <= cnt_nx;
      end

      pw_mask_q <= do_wr ? eff_mask : '0;
      if (do_wr) begin
        pw_addr_q <= acc_addr;
        pw_data_q <= wdata;
      end

      rd1_q <= do_rd;
      if (do_rd) st1_q <= rword;
      if (rd1_q) rdata_q <= st1_q;
      outv_q <= rd1_q && !do_wr && !desel && !sleep;
    end
  end

  assign rdata      = rdata_q;
  assign dq_oe      = outv_q && !oe_n && !sleep;
  assign strobe_err = err_q;
endmodule

module sbram_burst_ctrl_chk #(
  parameter int WW    = 2,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep,
  input logic             strobe_err,
  input logic [WW-1:0]    wake_q,
  input logic             rd1_q,
  input logic             outv_q,
  input logic [LANES-1:0] pw_mask_q
);
  p_err_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_err |-> $past(wake_q != '0));
  p_wr_mute_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_mask_q != '0) |-> !outv_q);
  p_sleep_mute_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep) |-> !outv_q);
  p_lock_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep || wake_q != '0) |=> (!rd1_q && pw_mask_q == '0));
  p_pipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    outv_q |-> $past(rd1_q));
endmodule

bind sbram_burst_ctrl sbram_burst_ctrl_chk #(.WW(WW), .LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .strobe_err(strobe_err),
  .wake_q(wake_q), .rd1_q(rd1_q), .outv_q(outv_q), .pw_mask_q(pw_mask_q)
);

// File: tb/sbram_burst_ctrl_tb.sv
`timescale 1ns/1ps
module sbram_burst_ctrl_tb_top;
  localparam int AW = 6, LANES = 2, LW = 9, DW = LANES * LW, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep, lin_mode, oe_n, sel_a_n, sel_b, sel_c_n;
  logic cpu_stb_n, ctl_stb_n, adv_n, all_wr_n, byte_wr_n;
  logic [LANES-1:0] lane_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic dq_oe, strobe_err;

  logic [DW-1:0] shadow [DEPTH];
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sbram_burst_ctrl #(.AW(AW), .LANES(LANES), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .lin_mode(lin_mode), .oe_n(oe_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .adv_n(adv_n),
    .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .dq_oe(dq_oe), .strobe_err(strobe_err));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    sleep = 0; oe_n = 0; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    cpu_stb_n = 1; ctl_stb_n = 1; adv_n = 1; all_wr_n = 1; byte_wr_n = 1;
    lane_wr_n = '1;
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    logic [31:0] v;
    v = (a * 12345 + salt * 977 + 3) ^ (a << 11);
    return v[DW-1:0];
  endfunction

  function automatic logic [AW-1:0] beat(input logic [AW-1:0] a, input int i, input bit lin);
    logic [1:0] lo;
    lo = lin ? a[1:0] + 2'(i) : a[1:0] ^ 2'(i);
    return {a[AW-1:2], lo};
  endfunction

  function automatic logic [LANES-1:0] dec(input bit aw, input bit bw, input logic [LANES-1:0] ln);
    if (!aw) return '1;
    if (!bw) return ~ln;
    return '0;
  endfunction

  task automatic ctl_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit aw, input bit bw, input logic [LANES-1:0] ln);
    logic [LANES-1:0] m;
    m = dec(aw, bw, ln);
    ctl_stb_n = 0; addr = a; wdata = d; all_wr_n = aw; byte_wr_n = bw; lane_wr_n = ln;
    tick();
    ctl_stb_n = 1; all_wr_n = 1; byte_wr_n = 1; lane_wr_n = '1;
    for (int l = 0; l < LANES; l++)
      if (m[l]) shadow[a][l*LW +: LW] = d[l*LW +: LW];
  endtask

  task automatic burst(input logic [AW-1:0] a, input bit lin);
    lin_mode = lin;
    cpu_stb_n = 0; ctl_stb_n = 0; all_wr_n = 0; addr = a; wdata = ~shadow[a];
    tick();
    cpu_stb_n = 1; ctl_stb_n = 1; all_wr_n = 1;
    for (int i = 0; i < 4; i++) begin
      adv_n = (i < 3) ? 1'b0 : 1'b1;
      tick();
      check("R7/R9/R4 burst data", rdata, shadow[beat(a, i, lin)]);
      check("R9 dq_oe during burst", dq_oe, 1);
    end
    adv_n = 1;
  endtask

  initial begin
    idle();
    lin_mode = 1; addr = '0; wdata = '0;
    repeat (3) tick();
    check("R1 rdata in reset", rdata, 0);
    check("R1 dq_oe in reset", dq_oe, 0);
    check("R1 strobe_err in reset", strobe_err, 0);
    rst_n = 1;
    tick();

    for (int a = 0; a < DEPTH; a++) begin
      ctl_write(AW'(a), pat(a, 0), 0, 1, '1);
      check("R10 R5 dq_oe low after write", dq_oe, 0);
    end

    for (int lin = 0; lin < 2; lin++)
      for (int a = 0; a < DEPTH; a++) burst(AW'(a), lin[0]);

    for (int ai = 0; ai < 4; ai++) begin
      for (int k = 0; k < 6; k++) begin
        logic [AW-1:0] a;
        bit aw, bw;
        logic [LANES-1:0] ln, m;
        a = AW'(ai * 13 + 1);
        case (k)
          0: begin aw = 0; bw = 1; ln = 2'b11; end
          1: begin aw = 0; bw = 0; ln = 2'b11; end
          2: begin aw = 1; bw = 0; ln = 2'b10; end
          3: begin aw = 1; bw = 0; ln = 2'b01; end
          4: begin aw = 1; bw = 0; ln = 2'b11; end
          default: begin aw = 1; bw = 1; ln = 2'b00; end
        endcase
        m = dec(aw, bw, ln);
        ctl_write(a, pat(a, k + 10), aw, bw, ln);
        cpu_stb_n = 0; addr = a;
        tick();
        cpu_stb_n = 1;
        check("R10 R6 dq_oe after write decode", dq_oe, (m == '0) ? 1 : 0);
        tick();
        check("R13 R6 bypass merged lanes", rdata, shadow[a]);
      end
    end

    lin_mode = 1;
    cpu_stb_n = 0; addr = 20;
    tick();
    cpu_stb_n = 1; all_wr_n = 0; adv_n = 1; wdata = pat(99, 1);
    tick();
    shadow[20] = pat(99, 1);
    adv_n = 0; wdata = pat(98, 2);
    tick();
    shadow[21] = pat(98, 2);
    all_wr_n = 1; adv_n = 1;
    tick();
    burst(20, 1);

    lin_mode = 0;
    cpu_stb_n = 0; addr = 10;
    tick();
    cpu_stb_n = 1; adv_n = 1;
    tick(); check("R8 suspend beat 0", rdata, shadow[10]);
    tick(); check("R8 suspend beat 0 again", rdata, shadow[10]);
    adv_n = 0;
    tick(); check("R8 advance shows prior beat", rdata, shadow[10]);
    adv_n = 1;
    tick(); check("R8 R7 interleaved next beat", rdata, shadow[11]);

    for (int c = 0; c < 8; c++) begin
      if (c == 3'b010) continue;
      cpu_stb_n = 0; addr = 30; lin_mode = 1;
      tick();
      cpu_stb_n = 1;
      {sel_a_n, sel_b, sel_c_n} = 3'(c);
      ctl_stb_n = 0; all_wr_n = 0; wdata = ~shadow[30]; addr = 30;
      tick();
      check("R2 deselect kills output", dq_oe, 0);
      idle();
      tick();
      check("R2 stays deselected", dq_oe, 0);
      burst(28, 1);
    end

    lin_mode = 1;
    cpu_stb_n = 0; addr = 40;
    tick();
    sel_a_n = 1; cpu_stb_n = 0; adv_n = 0; addr = 0;
    tick();
    check("R3 blocked strobe keeps burst data", rdata, shadow[40]);
    check("R3 blocked strobe keeps dq_oe", dq_oe, 1);
    idle();
    tick();
    check("R3 burst advanced", rdata, shadow[41]);

    cpu_stb_n = 0; addr = 44;
    tick();
    cpu_stb_n = 1;
    tick();
    check("R9 pre-sleep read", dq_oe, 1);
    sleep = 1;
    #1;
    check("R10 sleep gates dq_oe", dq_oe, 0);
    ctl_stb_n = 0; all_wr_n = 0; wdata = ~shadow[44]; addr = 44;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R12 no error while asleep", strobe_err, 0);
      check("R11 dark while asleep", dq_oe, 0);
    end
    sleep = 0;
    tick(); check("R12 lockout edge 1", strobe_err, 1);
    tick(); check("R12 lockout edge 2", strobe_err, 1);
    ctl_stb_n = 1; all_wr_n = 1; cpu_stb_n = 0; addr = 44;
    tick(); check("R12 accepted after lockout", strobe_err, 0);
    cpu_stb_n = 1;
    tick();
    check("R11 array preserved", rdata, shadow[44]);
    check("R11 read after wake", dq_oe, 1);
    oe_n = 1;
    #1;
    check("R10 oe_n gates dq_oe", dq_oe, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule